// File: doc/BRIEF.md
# Trigger and Tag Record Receiver

This block sits at the front end of a readout module and takes in trigger records sent by a central trigger distributor over a narrow backplane link. The link has one strobe line, one frame-marker line and a group of data lines. The block treats the strobe as a source-synchronous qualifier. It brings all the lines into the local clock domain and turns each strobe rising edge into one data beat. It then gathers the beats of a record into one wide word. Each record holds a 4-bit trigger code and a 96-bit tag. The tag carries an event number, a spill number and a timestamp in units of 8 ns.

Each completed record is handed to downstream readout as parallel fields, together with a one-hot decode of the trigger code. The block checks the tag against the history it keeps locally. The event number must advance by one on each level-1 trigger. The spill number may change only on a spill-start record. The timestamp must increase. Any violation sets a sticky synchronization error, and the record is still passed on. A frame marker that arrives in the middle of a record sets a sticky framing error. A busy line tells the distributor when the block cannot take a new record.

Top module: `trig_tag_rx`

## Requirements
- R1: After the configured synchronizer delay, each rising edge of `lnk_stb` delivers one beat of `LANES` bits taken from `lnk_dat`. A record is 20 beats with the default of 5 lanes. Its first beat carries `lnk_frm`=1, and the record is sent most-significant bit first. Record layout: bits [99:96] are the trigger code, [95:64] the event number, [63:48] the spill number and [47:0] the timestamp.
- R2: A beat with `lnk_frm`=0 that arrives while no record is being assembled is ignored. It changes no output.
- R3: When the last beat of a record arrives, `rec_valid` rises with the record fields. Valid and fields then hold until `rec_ready` is sampled high. If another record completes while one is still pending, the new record overwrites it.
- R4: `rec_kind` is a one-hot decode of the trigger code. Bit 0 is code 1 (level-1 physics). Bit 1 is code 2 (spill start). Bit 2 is code 3 (spill stop). Bit 3 is code 4 (calibration). Bit 4 is code 5 (hit-count sample). Bit 5 is code 6 (upset-count sample). Any other code gives all zeros.
- R5: A level-1 record whose event number is not the previous level-1 event number plus one (modulo 2^32) sets `sync_err`. The first level-1 record after reset is not checked, and non-level-1 records are never checked on event number.
- R6: Any record other than spill start whose spill number differs from the previous record's spill number sets `sync_err`.
- R7: A record whose timestamp is not strictly greater than the previous record's timestamp sets `sync_err`.
- R8: `sync_err` stays set until `err_clr` is sampled high, and a new violation in the same cycle wins over the clear. The flagged record is still forwarded. The stored references (last timestamp, last spill, and last level-1 event) are reloaded from every received record.
- R9: A beat with `lnk_frm`=1 during assembly discards the partial record, sets `frame_err` and starts a new record with that beat. `frame_err` is sticky and is cleared by `err_clr`, with set winning over clear.
- R10: `busy` is high exactly while a record is partly assembled or a completed record is pending.
- R11: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_stb | input | 1 | Link strobe; each rising edge marks a beat |
| lnk_frm | input | 1 | Frame marker, high on a record's first beat |
| lnk_dat | input | LANES | Link data lines |
| err_clr | input | 1 | Clears both sticky error flags |
| rec_ready | input | 1 | Downstream takes the pending record |
| rec_valid | output | 1 | A completed record is pending |
| rec_trig | output | 4 | Trigger code |
| rec_kind | output | 6 | One-hot trigger decode |
| rec_evt | output | 32 | Event number |
| rec_spill | output | 16 | Spill number |
| rec_ts | output | 48 | Timestamp, 8 ns units |
| sync_err | output | 1 | Sticky event synchronization error |
| frame_err | output | 1 | Sticky framing error |
| busy | output | 1 | Back-pressure toward the distributor |

## Verification
The bench builds the block with its defaults: 5 data lanes and a two-stage synchronizer, so each record takes 20 beats and a beat appears two clocks after its strobe edge. These values give full-width fields. That brings an event number wrap from all-ones to zero and timestamps near the top of the 48-bit range within reach. The two-stage delay also lets the per-clock reference model confirm the exact cycle in which `busy`, `rec_valid` and the error flags change.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TRIG_W  = 4;
    localparam int EVT_W   = 32;
    localparam int SPILL_W = 16;
    localparam int TS_W    = 48;
    localparam int REC_W   = TRIG_W + EVT_W + SPILL_W + TS_W;
    localparam int KIND_N  = 6;

    localparam logic [TRIG_W-1:0] TRG_L1        = 4'h1;
    localparam logic [TRIG_W-1:0] TRG_SPILL_ON  = 4'h2;
    localparam logic [TRIG_W-1:0] TRG_SPILL_OFF = 4'h3;
    localparam logic [TRIG_W-1:0] TRG_CALIB     = 4'h4;
    localparam logic [TRIG_W-1:0] TRG_HITCNT    = 4'h5;
    localparam logic [TRIG_W-1:0] TRG_SEUCNT    = 4'h6;

    // Field order is the on-wire order, most significant first
    typedef struct packed {
        logic [TRIG_W-1:0]  trig;
        logic [EVT_W-1:0]   evt;
        logic [SPILL_W-1:0] spill;
        logic [TS_W-1:0]    ts;
    } rec_t;
endpackage

// File: rtl/tt_link_sync.sv
module tt_link_sync #(
    parameter int LANES  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lnk_stb,
    input  logic             lnk_frm,
    input  logic [LANES-1:0] lnk_dat,
    output logic             beat,
    output logic             beat_frm,
    output logic [LANES-1:0] beat_dat
);
    localparam int W = LANES + 2;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic                     stb_prev;
    } sync_st_t;

    sync_st_t q, d;
    logic [W-1:0] tail;

    always_comb begin
        d = q;
        d.pipe[0] = {lnk_stb, lnk_frm, lnk_dat};
        for (int i = 1; i < STAGES; i++) begin
            d.pipe[i] = q.pipe[i-1];
        end
        d.stb_prev = q.pipe[STAGES-1][W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tail     = q.pipe[STAGES-1];
    assign beat     = tail[W-1] & ~q.stb_prev;
    assign beat_frm = tail[W-2];
    assign beat_dat = tail[LANES-1:0];

    AST_BEAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> !beat); // R1
endmodule

// File: rtl/tt_deframer.sv
module tt_deframer #(
    parameter int LANES = 5,
    parameter int REC_W = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             beat_frm,
    input  logic [LANES-1:0] beat_dat,
    output logic             done,
    output logic             abort,
    output logic             assembling,
    output logic [REC_W-1:0] rec_bits
);
    localparam int BEATS = (REC_W + LANES - 1) / LANES;
    localparam int SR_W  = BEATS * LANES;
    localparam int CNT_W = $clog2(BEATS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SR_W-1:0]  sr;
    } dfr_st_t;

    dfr_st_t q, d;
    logic [SR_W-1:0] shifted;

    always_comb begin
        d       = q;
        done    = 1'b0;
        abort   = 1'b0;
        shifted = {q.sr[SR_W-LANES-1:0], beat_dat};
        if (beat) begin
            if (beat_frm) begin
                abort = (q.cnt != '0);
                d.sr  = shifted;
                d.cnt = CNT_W'(1);
            end else if (q.cnt != '0) begin
                d.sr = shifted;
                if (q.cnt == CNT_W'(BEATS - 1)) begin
                    d.cnt = '0;
                    done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign assembling = (q.cnt != '0);
    assign rec_bits   = shifted[REC_W-1:0];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(BEATS)); // R1
    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> assembling); // R9
    AST_IDLE_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !beat_frm && !assembling) |=> !assembling); // R2
endmodule

// File: rtl/tt_tag_check.sv
module tt_tag_check
    import tt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  rec_t rec,
    input  logic err_clr,
    output logic sync_err
);
    typedef struct packed {
        logic               have_any;
        logic               have_l1;
        logic [TS_W-1:0]    last_ts;
        logic [SPILL_W-1:0] last_spill;
        logic [EVT_W-1:0]   last_evt;
        logic               err;
    } chk_st_t;

    chk_st_t q, d;
    logic    ts_bad, spill_bad, evt_bad;

    always_comb begin
        d         = q;
        ts_bad    = q.have_any && (rec.ts <= q.last_ts);
        spill_bad = q.have_any && (rec.trig != TRG_SPILL_ON) && (rec.spill != q.last_spill);
        evt_bad   = (rec.trig == TRG_L1) && q.have_l1 && (rec.evt != q.last_evt + EVT_W'(1));
        if (err_clr) d.err = 1'b0;
        if (done) begin
            if (ts_bad || spill_bad || evt_bad) d.err = 1'b1;
            d.have_any   = 1'b1;
            d.last_ts    = rec.ts;
            d.last_spill = rec.spill;
            if (rec.trig == TRG_L1) begin
                d.have_l1  = 1'b1;
                d.last_evt = rec.evt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_err = q.err;

    AST_SYNC_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !err_clr) |=> sync_err); // R8
endmodule

// File: rtl/trig_tag_rx.sv
module trig_tag_rx
    import tt_pkg::*;
#(
    parameter int LANES       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lnk_stb,
    input  logic               lnk_frm,
    input  logic [LANES-1:0]   lnk_dat,
    input  logic               err_clr,
    input  logic               rec_ready,
    output logic               rec_valid,
    output logic [TRIG_W-1:0]  rec_trig,
    output logic [KIND_N-1:0]  rec_kind,
    output logic [EVT_W-1:0]   rec_evt,
    output logic [SPILL_W-1:0] rec_spill,
    output logic [TS_W-1:0]    rec_ts,
    output logic               sync_err,
    output logic               frame_err,
    output logic               busy
);
    logic             beat, beat_frm;
    logic [LANES-1:0] beat_dat;
    logic             dfr_done, dfr_abort, dfr_asm;
    logic [REC_W-1:0] dfr_bits;
    rec_t             dfr_rec;

    tt_link_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .lnk_stb(lnk_stb), .lnk_frm(lnk_frm), .lnk_dat(lnk_dat),
        .beat(beat), .beat_frm(beat_frm), .beat_dat(beat_dat)
    );

    tt_deframer #(.LANES(LANES), .REC_W(REC_W)) i_dfr (
        .clk(clk), .rst_n(rst_n),
        .beat(beat), .beat_frm(beat_frm), .beat_dat(beat_dat),
        .done(dfr_done), .abort(dfr_abort), .assembling(dfr_asm),
        .rec_bits(dfr_bits)
    );

    assign dfr_rec = rec_t'(dfr_bits);

    tt_tag_check i_chk (
        .clk(clk), .rst_n(rst_n),
        .done(dfr_done), .rec(dfr_rec), .err_clr(err_clr),
        .sync_err(sync_err)
    );

    typedef struct packed {
        logic              valid;
        rec_t              rec;
        logic [KIND_N-1:0] kind;
        logic              ferr;
    } out_st_t;

    out_st_t q, d;

    always_comb begin
        d = q;
        if (rec_ready && q.valid) d.valid = 1'b0;
        if (err_clr)              d.ferr  = 1'b0;
        if (dfr_abort)            d.ferr  = 1'b1;
        if (dfr_done) begin
            d.valid = 1'b1;
            d.rec   = dfr_rec;
            for (int k = 0; k < KIND_N; k++) begin
                d.kind[k] = (dfr_rec.trig == TRIG_W'(k + 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rec_valid = q.valid;
    assign rec_trig  = q.rec.trig;
    assign rec_kind  = q.kind;
    assign rec_evt   = q.rec.evt;
    assign rec_spill = q.rec.spill;
    assign rec_ts    = q.rec.ts;
    assign frame_err = q.ferr;
    assign busy      = dfr_asm | q.valid;

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> rec_valid); // R3
    AST_TAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready && !dfr_done) |=> ($stable(rec_evt) && $stable(rec_ts))); // R3
    AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rec_kind)); // R4
    AST_FRAME_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err); // R9
endmodule

// File: tb/test_trig_tag_rx.sv
module test_trig_tag_rx;
    localparam int LANES = 5;
    localparam int STG   = 2;
    localparam int NBEAT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             lnk_stb = 1'b0, lnk_frm = 1'b0;
    logic [LANES-1:0] lnk_dat = '0;
    logic             err_clr = 1'b0, rec_ready = 1'b0;
    logic             rec_valid, sync_err, frame_err, busy;
    logic [3:0]       rec_trig;
    logic [5:0]       rec_kind;
    logic [31:0]      rec_evt;
    logic [15:0]      rec_spill;
    logic [47:0]      rec_ts;

    trig_tag_rx #(.LANES(LANES), .SYNC_STAGES(STG)) i_trig_tag_rx (
        .clk(clk), .rst_n(rst_n), .lnk_stb(lnk_stb), .lnk_frm(lnk_frm), .lnk_dat(lnk_dat),
        .err_clr(err_clr), .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_trig(rec_trig),
        .rec_kind(rec_kind), .rec_evt(rec_evt), .rec_spill(rec_spill), .rec_ts(rec_ts),
        .sync_err(sync_err), .frame_err(frame_err), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [LANES+1:0] hist[$];
    logic [LANES+1:0] cur, prv;
    int          m_cnt;
    logic [99:0] m_bits;
    logic        m_valid, m_serr, m_ferr, m_any, m_l1;
    logic [3:0]  m_trig;
    logic [31:0] m_evt, m_last_evt;
    logic [15:0] m_spill, m_last_spill;
    logic [47:0] m_ts, m_last_ts;

    function automatic void model_reset();
        hist.delete();
        for (int i = 0; i <= STG; i++) hist.push_back('0);
        m_cnt = 0; m_bits = '0; m_valid = 0; m_serr = 0; m_ferr = 0; m_any = 0; m_l1 = 0;
        m_trig = '0; m_evt = '0; m_last_evt = '0; m_spill = '0; m_last_spill = '0;
        m_ts = '0; m_last_ts = '0;
    endfunction

    function automatic void model_complete();
        logic [3:0]  t  = m_bits[99:96];
        logic [31:0] e  = m_bits[95:64];
        logic [15:0] s  = m_bits[63:48];
        logic [47:0] ts = m_bits[47:0];
        bit bad = 0;
        if (m_any && ts <= m_last_ts) bad = 1;
        if (m_any && t != 4'h2 && s != m_last_spill) bad = 1;
        if (t == 4'h1 && m_l1 && e != m_last_evt + 32'd1) bad = 1;
        if (bad) m_serr = 1;
        m_any = 1; m_last_ts = ts; m_last_spill = s;
        if (t == 4'h1) begin m_l1 = 1; m_last_evt = e; end
        m_valid = 1; m_trig = t; m_evt = e; m_spill = s; m_ts = ts;
    endfunction

    function automatic void model_beat(input logic f, input logic [LANES-1:0] dv);
        if (f) begin
            if (m_cnt > 0) m_ferr = 1;
            m_bits = {m_bits[94:0], dv};
            m_cnt = 1;
        end else if (m_cnt > 0) begin
            m_bits = {m_bits[94:0], dv};
            m_cnt++;
            if (m_cnt == NBEAT) begin m_cnt = 0; model_complete(); end
        end
    endfunction

    function automatic logic [5:0] kind_of(input logic [3:0] t);
        return (t >= 4'd1 && t <= 4'd6) ? 6'(1 << (t - 1)) : 6'd0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            cur = hist[STG-1];
            prv = hist[STG];
            if (rec_ready && m_valid) m_valid = 0;
            if (err_clr) begin m_serr = 0; m_ferr = 0; end
            if (cur[LANES+1] && !prv[LANES+1]) model_beat(cur[LANES], cur[LANES-1:0]);
            hist.push_front({lnk_stb, lnk_frm, lnk_dat});
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 model rec_valid", 64'(rec_valid), 64'(m_valid));
            chk("R1 model rec_trig",  64'(rec_trig),  64'(m_trig));
            chk("R1 model rec_evt",   64'(rec_evt),   64'(m_evt));
            chk("R1 model rec_spill", 64'(rec_spill), 64'(m_spill));
            chk("R1 model rec_ts",    64'(rec_ts),    64'(m_ts));
            chk("R4 model rec_kind",  64'(rec_kind),  64'(kind_of(m_trig)));
            chk("R10 model busy",     64'(busy),      64'((m_cnt != 0) || m_valid));
            chk("R5 R6 R7 R8 model sync_err", 64'(sync_err), 64'(m_serr));
            chk("R9 model frame_err", 64'(frame_err), 64'(m_ferr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_beat(input logic f, input logic [LANES-1:0] dv);
        @(negedge clk); lnk_frm = f; lnk_dat = dv; lnk_stb = 1'b0;
        @(negedge clk); lnk_stb = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_rec(input logic [3:0] t, input logic [31:0] e,
                            input logic [15:0] s, input logic [47:0] ts);
        logic [99:0] bits = {t, e, s, ts};
        for (int b = 0; b < NBEAT; b++) send_beat(b == 0, bits[99 - 5*b -: 5]);
        @(negedge clk); lnk_stb = 1'b0; lnk_frm = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic consume();
        @(negedge clk); rec_ready = 1'b1;
        @(negedge clk); rec_ready = 1'b0;
    endtask

    task automatic clear_errs();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset valid", 64'(rec_valid), 0);
        chk("R11 reset busy", 64'(busy), 0);
        chk("R11 reset errs", 64'({sync_err, frame_err}), 0);
        chk("R11 reset evt", 64'(rec_evt), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 stray beats while idle
        for (int i = 0; i < 3; i++) send_beat(1'b0, 5'h1F);
        @(negedge clk); lnk_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 stray busy", 64'(busy), 0);
        chk("R2 stray valid", 64'(rec_valid), 0);

        // R1 R3 R4 first record
        send_rec(4'h1, 32'd100, 16'd7, 48'd1000);
        chk("R3 valid", 64'(rec_valid), 1);
        chk("R1 evt", 64'(rec_evt), 100);
        chk("R1 ts", 64'(rec_ts), 1000);
        chk("R4 kind L1", 64'(rec_kind), 64'h01);
        chk("R10 busy pending", 64'(busy), 1);
        consume();
        @(negedge clk);
        chk("R10 busy after consume", 64'(busy), 0);

        send_rec(4'h1, 32'd101, 16'd7, 48'd2000);
        chk("R5 in-order no err", 64'(sync_err), 0);
        consume();

        // R5 gap
        send_rec(4'h1, 32'd105, 16'd7, 48'd3000);
        chk("R5 gap err", 64'(sync_err), 1);
        consume();
        send_rec(4'h1, 32'd106, 16'd7, 48'd4000);
        chk("R8 sticky", 64'(sync_err), 1);
        chk("R8 forwarded", 64'(rec_evt), 106);
        consume();
        clear_errs();
        @(negedge clk);
        chk("R8 cleared", 64'(sync_err), 0);
        send_rec(4'h1, 32'd107, 16'd7, 48'd5000);
        chk("R8 resync", 64'(sync_err), 0);
        consume();

        // R5 non-L1 event ignored, R4 calibration
        send_rec(4'h4, 32'd5, 16'd7, 48'd6000);
        chk("R5 calib event unchecked", 64'(sync_err), 0);
        chk("R4 kind calib", 64'(rec_kind), 64'h08);
        consume();

        // R6 spill
        send_rec(4'h3, 32'd0, 16'd7, 48'd7000);
        chk("R4 kind stop", 64'(rec_kind), 64'h04);
        consume();
        send_rec(4'h2, 32'd0, 16'd8, 48'd8000);
        chk("R6 spill start ok", 64'(sync_err), 0);
        consume();
        send_rec(4'h1, 32'd108, 16'd9, 48'd9000);
        chk("R6 spill change err", 64'(sync_err), 1);
        consume();
        clear_errs();

        // R7 timestamp equal
        send_rec(4'h1, 32'd109, 16'd9, 48'd9000);
        chk("R7 ts equal err", 64'(sync_err), 1);
        consume();
        clear_errs();

        // R5 wrap
        send_rec(4'h1, 32'hFFFF_FFFF, 16'd9, 48'd10000);
        consume();
        clear_errs();
        send_rec(4'h1, 32'd0, 16'd9, 48'd11000);
        chk("R5 wrap ok", 64'(sync_err), 0);
        consume();

        // R9 abort mid-record, R10 busy during assembly
        for (int b = 0; b < 7; b++) send_beat(b == 0, 5'h0A);
        @(negedge clk); lnk_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 busy assembling", 64'(busy), 1);
        chk("R9 no err yet", 64'(frame_err), 0);
        send_rec(4'h1, 32'd1, 16'd9, 48'd12000);
        chk("R9 frame err", 64'(frame_err), 1);
        chk("R9 new record", 64'(rec_evt), 1);
        chk("R9 sync ok", 64'(sync_err), 0);
        consume();
        clear_errs();
        @(negedge clk);
        chk("R9 cleared", 64'(frame_err), 0);

        // R3 overwrite, R4 codes
        send_rec(4'h5, 32'd0, 16'd9, 48'd13000);
        chk("R4 kind hit", 64'(rec_kind), 64'h10);
        send_rec(4'h6, 32'd0, 16'd9, 48'd14000);
        chk("R3 overwrite ts", 64'(rec_ts), 14000);
        chk("R4 kind seu", 64'(rec_kind), 64'h20);
        consume();
        send_rec(4'hF, 32'd0, 16'd9, 48'hFFFF_FFFF_FFF0);
        chk("R4 unknown code", 64'(rec_kind), 0);
        chk("R1 top ts", 64'(rec_ts), 64'hFFFF_FFFF_FFF0);
        consume();

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule